// File: doc/BRIEF.md
# CAN controller interrupt unit

This block produces the four interrupt request lines of a CAN protocol controller: transmit, receive, wake-up and error. It watches status coming from the rest of the controller and keeps one flag per interrupt cause. The causes are the empty state of each transmit buffer, the arrival of a received frame, bus activity while asleep, a receive FIFO overrun, and a change in the bus state derived from the error counters. Each interrupt line is the OR of its flags, each flag masked by its own enable bit. Software reads the flags and clears them by writing ones.

The transmit and receive error counters are mapped onto small bus-state codes, and those codes are stored. When either stored code changes, the status-change flag is raised, and the stored codes are readable so the cause can be found. The receive flag is handled by a small state machine with three states. In RX_IDLE no message waits. In RX_FULL the flag is up. In RX_SHIFT the host has just released a message while others remain, and the next one is moving into the foreground. There are four transitions:
- RX_IDLE to RX_FULL on an end-of-frame event.
- RX_FULL to RX_SHIFT on a clear when more than one message is queued.
- RX_FULL to RX_IDLE on a clear when at most one message is queued.
- RX_SHIFT to RX_FULL always, one cycle later.

An end-of-frame event in any state leads to RX_FULL.

Top module: `can_irq_unit`

## Requirements
- R1: After synchronous reset all flags, enables and stored bus-state codes are zero and all four interrupt outputs are low.
- R2: Flag bit layout: bits 0..2 are the transmit-empty flags of buffers 0..2, bit 3 receive, bit 4 wake-up, bit 5 status change, bit 6 overrun. Enable bits use the same positions, and bit 7 enables the wake-up function. irq_tx_o is the OR of enabled bits 0..2, irq_rx_o is enabled bit 3, irq_wake_o is enabled bit 4, and irq_err_o is the OR of enabled bits 5 and 6. A flag is set whatever its enable bit holds.
- R3: A transmit-empty flag is set in the cycle after its buffer's empty input is high, and it stays set until cleared.
- R4: The receive flag is set in the cycle after an end-of-frame event.
- R5: If the host clears the receive flag while the FIFO occupancy is 2 or more, the flag reads 0 for one cycle and then 1 again. If the occupancy is 0 or 1, the flag stays 0.
- R6: The wake-up flag is set only when sleep mode, bus activity and the wake-up function enable (enable bit 7) are all active in the same cycle.
- R7: The overrun flag is set in the cycle after an overrun pulse.
- R8: Transmitter code: 00 for counts 0..95, 01 for 96..127, 10 for 128..255, 11 above 255. Receiver code: 00 below 96, 01 for 96..127, 10 for 128 and above. Each code reflects the counter value of the previous cycle.
- R9: The status-change flag is set in the same cycle that either stored code changes. A counter move that stays inside one range does not set it.
- R10: Writing 1 to a flag bit clears the flag in the next cycle. A set event in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_empty_i | input | NUM_TX (3) | Per-buffer empty and not scheduled level |
| rx_eof_i | input | 1 | End-of-frame pulse of a good received message |
| rx_occ_i | input | OCC_W (3) | Messages held in the receive FIFO, foreground included |
| sleep_i | input | 1 | Internal sleep mode active |
| bus_act_i | input | 1 | Bus activity seen |
| rx_ovr_i | input | 1 | Receive FIFO overrun pulse |
| tx_err_cnt_i | input | CNT_W (9) | Transmit error counter |
| rx_err_cnt_i | input | CNT_W (9) | Receive error counter |
| ien_we_i | input | 1 | Enable register write strobe |
| ien_wdata_i | input | NFLAG+1 (8) | Enable register write data |
| flag_clr_i | input | NFLAG (7) | Write-one-to-clear strobes for the flags |
| flags_o | output | NFLAG (7) | Flag register |
| tx_state_o | output | 2 | Stored transmitter bus-state code |
| rx_state_o | output | 2 | Stored receiver bus-state code |
| irq_tx_o | output | 1 | Transmit interrupt |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_wake_o | output | 1 | Wake-up interrupt |
| irq_err_o | output | 1 | Error interrupt |

## Verification
A host clear and a new set event for the same flag can land in the same cycle. The bench provokes this in two ways: it pulses an overrun together with a clear of the overrun bit, and it clears the receive flag in the cycle an end-of-frame arrives. In both cases the flag must read 1 afterwards. The bench also sweeps both error counters across their full ranges and computes the expected codes and the status-change flag arithmetically. It checks every pattern of transmit-empty inputs against every enable pattern.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_FULL  = 2'd1,
        RX_SHIFT = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        BS_OK   = 2'b00,
        BS_WARN = 2'b01,
        BS_ERR  = 2'b10,
        BS_OFF  = 2'b11
    } bus_state_e;

endpackage

// File: rtl/can_bus_state.sv
module can_bus_state
    import can_irq_pkg::*;
#(
    parameter int CNT_W   = 9,
    parameter int WARN_AT = 96,
    parameter int ERR_AT  = 128,
    parameter int OFF_AT  = 256,
    parameter bit HAS_OFF = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [1:0]       code_o,
    output logic             chg_o
);
    localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_AT);
    localparam logic [CNT_W-1:0] ERR_V  = CNT_W'(ERR_AT);
    localparam logic [CNT_W-1:0] OFF_V  = CNT_W'(OFF_AT);

    bus_state_e code_d, code_q;
    logic       above_off;

    generate
        if (HAS_OFF) begin : g_off
            assign above_off = (cnt_i >= OFF_V);
        end else begin : g_no_off
            assign above_off = 1'b0;
        end
    endgenerate

    always_comb begin
        if (above_off)             code_d = BS_OFF;
        else if (cnt_i >= ERR_V)   code_d = BS_ERR;
        else if (cnt_i >= WARN_V)  code_d = BS_WARN;
        else                       code_d = BS_OK;
    end

    always_ff @(posedge clk) begin
        if (rst) code_q <= BS_OK;
        else     code_q <= code_d;
    end

    always_comb begin
        code_o = code_q;
        chg_o  = (code_d != code_q);
    end

    // R8
    low_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_i < WARN_V) |=> (code_q == BS_OK));
    // R8
    warn_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_i >= WARN_V && cnt_i < ERR_V) |=> (code_q == BS_WARN));

endmodule

// File: rtl/can_rx_flag_fsm.sv
module can_rx_flag_fsm
    import can_irq_pkg::*;
#(
    parameter int OCC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eof_i,
    input  logic             clr_i,
    input  logic [OCC_W-1:0] occ_i,
    output logic             flag_o
);
    localparam logic [OCC_W-1:0] ONE = OCC_W'(1);

    rx_state_e state_q, state_d;
    logic      more_queued;

    assign more_queued = (occ_i > ONE);

    always_ff @(posedge clk) begin
        if (rst) state_q <= RX_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (eof_i) state_d = RX_FULL;
            RX_FULL: begin
                if (!eof_i && clr_i) state_d = more_queued ? RX_SHIFT : RX_IDLE;
            end
            RX_SHIFT: state_d = RX_FULL;
            default:  state_d = RX_IDLE;
        endcase
    end

    always_comb begin
        flag_o = (state_q == RX_FULL);
    end

    // R4
    eof_sets_chk: assert property (@(posedge clk) disable iff (rst)
        eof_i |=> flag_o);
    // R5
    rearm_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_o && clr_i && !eof_i && more_queued) |=> (state_q == RX_SHIFT));
    // R5
    rearm_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_SHIFT) |=> flag_o);

endmodule

// File: rtl/can_w1c_flags.sv
module can_w1c_flags #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)           q_o[i] <= 1'b0;
                else if (set_i[i]) q_o[i] <= 1'b1;
                else if (clr_i[i]) q_o[i] <= 1'b0;
            end

            // R10
            set_wins_chk: assert property (@(posedge clk) disable iff (rst)
                set_i[i] |=> q_o[i]);
            // R10
            clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
                (clr_i[i] && !set_i[i]) |=> !q_o[i]);
        end
    endgenerate

endmodule

// File: rtl/can_irq_unit.sv
module can_irq_unit
    import can_irq_pkg::*;
#(
    parameter int NUM_TX     = 3,
    parameter int CNT_W      = 9,
    parameter int FIFO_DEPTH = 5,
    localparam int NFLAG     = NUM_TX + 4,
    localparam int OCC_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_TX-1:0] tx_empty_i,
    input  logic              rx_eof_i,
    input  logic [OCC_W-1:0]  rx_occ_i,
    input  logic              sleep_i,
    input  logic              bus_act_i,
    input  logic              rx_ovr_i,
    input  logic [CNT_W-1:0]  tx_err_cnt_i,
    input  logic [CNT_W-1:0]  rx_err_cnt_i,
    input  logic              ien_we_i,
    input  logic [NFLAG:0]    ien_wdata_i,
    input  logic [NFLAG-1:0]  flag_clr_i,
    output logic [NFLAG-1:0]  flags_o,
    output logic [1:0]        tx_state_o,
    output logic [1:0]        rx_state_o,
    output logic              irq_tx_o,
    output logic              irq_rx_o,
    output logic              irq_wake_o,
    output logic              irq_err_o
);
    localparam int RX_B  = NUM_TX;
    localparam int WK_B  = NUM_TX + 1;
    localparam int CSC_B = NUM_TX + 2;
    localparam int OVR_B = NUM_TX + 3;
    localparam int WKE_B = NFLAG;
    localparam int NOTH  = NUM_TX + 3;

    logic [NFLAG:0]   ien_q;
    logic             tx_chg, rx_chg, rx_flag;
    logic [NOTH-1:0]  oth_set, oth_clr, oth_q;
    logic [NFLAG-1:0] masked;

    always_ff @(posedge clk) begin
        if (rst)           ien_q <= '0;
        else if (ien_we_i) ien_q <= ien_wdata_i;
    end

    can_bus_state #(.CNT_W(CNT_W), .HAS_OFF(1'b1)) u_tx_state (
        .clk(clk), .rst(rst), .cnt_i(tx_err_cnt_i),
        .code_o(tx_state_o), .chg_o(tx_chg)
    );

    can_bus_state #(.CNT_W(CNT_W), .HAS_OFF(1'b0)) u_rx_state (
        .clk(clk), .rst(rst), .cnt_i(rx_err_cnt_i),
        .code_o(rx_state_o), .chg_o(rx_chg)
    );

    can_rx_flag_fsm #(.OCC_W(OCC_W)) u_rx_fsm (
        .clk(clk), .rst(rst), .eof_i(rx_eof_i),
        .clr_i(flag_clr_i[RX_B]), .occ_i(rx_occ_i), .flag_o(rx_flag)
    );

    always_comb begin
        oth_set = {rx_ovr_i, tx_chg | rx_chg,
                   sleep_i & bus_act_i & ien_q[WKE_B], tx_empty_i};
        oth_clr = {flag_clr_i[OVR_B], flag_clr_i[CSC_B],
                   flag_clr_i[WK_B], flag_clr_i[NUM_TX-1:0]};
    end

    can_w1c_flags #(.N(NOTH)) u_flags (
        .clk(clk), .rst(rst), .set_i(oth_set), .clr_i(oth_clr), .q_o(oth_q)
    );

    always_comb begin
        flags_o    = {oth_q[NOTH-1:NUM_TX], rx_flag, oth_q[NUM_TX-1:0]};
        masked     = flags_o & ien_q[NFLAG-1:0];
        irq_tx_o   = |masked[NUM_TX-1:0];
        irq_rx_o   = masked[RX_B];
        irq_wake_o = masked[WK_B];
        irq_err_o  = masked[CSC_B] | masked[OVR_B];
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (flags_o == '0 && tx_state_o == 2'b00 && rx_state_o == 2'b00
                        && !irq_tx_o && !irq_rx_o && !irq_wake_o && !irq_err_o));
    // R6
    wake_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_o[WK_B]) |-> $past(sleep_i && bus_act_i && ien_q[WKE_B]));
    // R9
    status_change_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(tx_state_o) || !$stable(rx_state_o)) |-> flags_o[CSC_B]);
    // R7
    overrun_chk: assert property (@(posedge clk) disable iff (rst)
        rx_ovr_i |=> flags_o[OVR_B]);

endmodule

// File: tb/can_irq_unit_bench.sv
module can_irq_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] tx_empty_i = '0;
    logic       rx_eof_i = 1'b0;
    logic [2:0] rx_occ_i = '0;
    logic       sleep_i = 1'b0, bus_act_i = 1'b0, rx_ovr_i = 1'b0;
    logic [8:0] tx_err_cnt_i = '0, rx_err_cnt_i = '0;
    logic       ien_we_i = 1'b0;
    logic [7:0] ien_wdata_i = '0;
    logic [6:0] flag_clr_i = '0;
    logic [6:0] flags_o;
    logic [1:0] tx_state_o, rx_state_o;
    logic       irq_tx_o, irq_rx_o, irq_wake_o, irq_err_o;

    int n_cmp = 0;
    int n_bad = 0;
    int prev_tx = 0, prev_rx = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    can_irq_unit u_can_irq_unit (
        .clk(clk), .rst(rst), .tx_empty_i(tx_empty_i), .rx_eof_i(rx_eof_i),
        .rx_occ_i(rx_occ_i), .sleep_i(sleep_i), .bus_act_i(bus_act_i),
        .rx_ovr_i(rx_ovr_i), .tx_err_cnt_i(tx_err_cnt_i), .rx_err_cnt_i(rx_err_cnt_i),
        .ien_we_i(ien_we_i), .ien_wdata_i(ien_wdata_i), .flag_clr_i(flag_clr_i),
        .flags_o(flags_o), .tx_state_o(tx_state_o), .rx_state_o(rx_state_o),
        .irq_tx_o(irq_tx_o), .irq_rx_o(irq_rx_o), .irq_wake_o(irq_wake_o),
        .irq_err_o(irq_err_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tx_code(input int v);
        return (v > 255) ? 3 : (v >= 128) ? 2 : (v >= 96) ? 1 : 0;
    endfunction

    function automatic int rx_code(input int v);
        return (v >= 128) ? 2 : (v >= 96) ? 1 : 0;
    endfunction

    task automatic write_en(input logic [7:0] d);
        ien_we_i = 1'b1; ien_wdata_i = d;
        @(negedge clk);
        ien_we_i = 1'b0;
    endtask

    task automatic pulse_clr(input logic [6:0] m);
        flag_clr_i = m;
        @(negedge clk);
        flag_clr_i = '0;
    endtask

    // R8 and R9: drive both counters, check codes and the status-change flag
    task automatic set_cnt(input int tv, input int rv);
        int et, er;
        et = tx_code(tv); er = rx_code(rv);
        tx_err_cnt_i = 9'(tv); rx_err_cnt_i = 9'(rv);
        @(negedge clk);
        chk("R8 tx code", int'(tx_state_o), et);
        chk("R8 rx code", int'(rx_state_o), er);
        chk("R9 status change", int'(flags_o[5]), (et != prev_tx || er != prev_rx) ? 1 : 0);
        prev_tx = et; prev_rx = er;
        pulse_clr(7'b0100000);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 flags", int'(flags_o), 0);
        chk("R1 states", int'({tx_state_o, rx_state_o}), 0);
        chk("R1 irqs", int'({irq_tx_o, irq_rx_o, irq_wake_o, irq_err_o}), 0);

        // R3, R2, R10: every empty pattern against every enable pattern
        for (int en = 0; en < 8; en++) begin
            for (int p = 0; p < 8; p++) begin
                write_en(8'(en));
                tx_empty_i = 3'(p);
                @(negedge clk);
                tx_empty_i = '0;
                chk("R3 tx flags", int'(flags_o[2:0]), p);
                chk("R2 irq_tx", int'(irq_tx_o), ((p & en) != 0) ? 1 : 0);
                @(negedge clk);
                chk("R3 tx flags held", int'(flags_o[2:0]), p);
                pulse_clr(7'b0000111);
                chk("R10 tx cleared", int'(flags_o[2:0]), 0);
            end
        end

        // R4 and R2 receive path
        write_en(8'b0000_1000);
        rx_eof_i = 1'b1;
        @(negedge clk);
        rx_eof_i = 1'b0;
        chk("R4 rx flag", int'(flags_o[3]), 1);
        chk("R2 irq_rx", int'(irq_rx_o), 1);
        // R5 re-raise with queued messages
        rx_occ_i = 3'd3;
        flag_clr_i = 7'b0001000;
        @(negedge clk);
        flag_clr_i = '0;
        chk("R5 rx drop", int'(flags_o[3]), 0);
        @(negedge clk);
        chk("R5 rx re-raise", int'(flags_o[3]), 1);
        // R10 clear against end-of-frame in the same cycle
        flag_clr_i = 7'b0001000; rx_eof_i = 1'b1;
        @(negedge clk);
        flag_clr_i = '0; rx_eof_i = 1'b0;
        chk("R10 rx set wins", int'(flags_o[3]), 1);
        // R5 last message released
        rx_occ_i = 3'd1;
        pulse_clr(7'b0001000);
        chk("R5 rx idle", int'(flags_o[3]), 0);
        @(negedge clk);
        chk("R5 rx stays idle", int'(flags_o[3]), 0);
        chk("R2 irq_rx low", int'(irq_rx_o), 0);

        // R6 wake-up gating
        for (int c = 0; c < 8; c++) begin
            write_en({c[2], 7'b0010000});
            sleep_i = c[0]; bus_act_i = c[1];
            @(negedge clk);
            sleep_i = 1'b0; bus_act_i = 1'b0;
            chk("R6 wake flag", int'(flags_o[4]), (c == 7) ? 1 : 0);
            chk("R2 irq_wake", int'(irq_wake_o), (c == 7) ? 1 : 0);
            pulse_clr(7'b0010000);
        end

        // R7, R10, R2 overrun and error line
        write_en(8'b0100_0000);
        rx_ovr_i = 1'b1; flag_clr_i = 7'b1000000;
        @(negedge clk);
        rx_ovr_i = 1'b0; flag_clr_i = '0;
        chk("R7 overrun flag", int'(flags_o[6]), 1);
        chk("R10 overrun set wins", int'(flags_o[6]), 1);
        chk("R2 irq_err", int'(irq_err_o), 1);
        write_en(8'b0000_0000);
        chk("R2 masked irq_err", int'(irq_err_o), 0);
        chk("R2 flag kept when masked", int'(flags_o[6]), 1);
        pulse_clr(7'b1000000);
        chk("R10 overrun cleared", int'(flags_o[6]), 0);

        // R8, R9 counter sweeps
        for (int v = 0; v <= 300; v++) set_cnt(v, 0);
        set_cnt(0, 0);
        for (int v = 0; v <= 300; v++) set_cnt(0, v);
        set_cnt(0, 0);
        write_en(8'b0010_0000);
        tx_err_cnt_i = 9'd130;
        @(negedge clk);
        chk("R2 irq_err status", int'(irq_err_o), 1);

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule